// File: doc/BRIEF.md
# Ping-Pong Frame Engine with 32-bit FCS

This block moves fixed-length serial frames between a byte-wide host port and a one-bit line. It keeps two transmit buffers and two receive buffers of `BUF_BYTES` bytes each (80 by default). The host fills a transmit buffer through a write-only byte port and marks it committed. The block alternates between the two buffers so the host can work on one while the other is on the line. A transmit frame carries the first `BUF_BYTES-4` bytes of the buffer, then a 32-bit frame check sequence (FCS) computed over those bytes. A received frame is stored whole, FCS included, into the current receive buffer. The host reads it back through a read-only byte port.

The frame length is `BUF_BYTES*8` bits (640 by default). The FCS covers only the leading `BUF_BYTES*8-32` bits (608 by default). Both directions advance one bit for each cycle in which the shared `bit_en` strobe is high and stand still otherwise. A start request is accepted only when the current buffer of that direction is in the right state. If it is not, the request is dropped and an overrun flag records that it happened.

Top module: `pingpong_fcs_engine`

## Requirements
- R1: After synchronous reset, every flag and pulse output reads 0. This covers both full masks, both busy signals, both overrun flags, `fcs_error`, `tx_bit`, `tx_vld`, `tx_done` and `rx_done`. Both current-buffer pointers read 0, which selects buffer A.
- R2: A transmit frame starts with the data bits taken from bytes 0 to `BUF_BYTES-5` of the current transmit buffer. Bytes go out in ascending address order and each byte goes out bit 0 first. The last four bytes of the buffer are never sent.
- R3: After the data bits, 32 FCS bits follow. The CRC register is preset to all ones. Each data bit d is then shifted in, in the order it is sent: the feedback bit is the register's bit 31 XOR d. The register shifts left, and when the feedback bit is 1 it is XORed with 0x04C11DB7. The FCS sent is the bitwise complement of the final register, bit 31 first.
- R4: One line bit is produced per cycle in which `bit_en` is high while the engine is running. `tx_vld` pulses in the cycle after that strobe, with the bit on `tx_bit`. There is no `tx_vld` without a strobe in the cycle before it. Gaps in the strobe do not alter the bit sequence.
- R5: `tx_commit` sets bit `tx_commit_sel` of `tx_full`. `tx_done` pulses for one cycle together with the `tx_vld` of the last FCS bit. In that same cycle, the sent buffer's `tx_full` bit is already clear and `tx_cur` has toggled.
- R6: A `tx_start` while idle, when the current transmit buffer is not committed, starts nothing and sets `tx_overrun`. The next accepted start clears it.
- R7: A receive frame of `BUF_BYTES*8` bits is stored into the current receive buffer: line bit k goes to byte k/8, bit k%8. The host read port returns the byte one cycle after `rx_rd_sel`/`rx_rd_addr` are applied.
- R8: The CRC of R3 is computed over the first `BUF_BYTES*8-32` received bits. It is compared with the last 32 bits, where the first of those bits is bit 31. `rx_done` pulses for one cycle in the cycle after the last bit's strobe. `fcs_error` is then 1 when the received field differs from the complemented CRC. It holds that value until the next accepted receive start, which clears it.
- R9: In the `rx_done` cycle, the filled buffer's `rx_full` bit is set and `rx_cur` has toggled. `rx_release` clears bit `rx_release_sel` of `rx_full`.
- R10: An `rx_start` while idle, when the current receive buffer is still full, starts nothing. It leaves `fcs_error` unchanged and sets `rx_overrun`. The next accepted start clears it.
- R11: A start request in either direction while that direction is busy is ignored. The frame runs on unchanged and the overrun flag does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Line bit strobe, shared by both directions |
| tx_wr_en | input | 1 | Host byte write into a transmit buffer |
| tx_wr_sel | input | 1 | Transmit buffer written (0 = A, 1 = B) |
| tx_wr_addr | input | $clog2(BUF_BYTES) | Byte address within the buffer |
| tx_wr_data | input | 8 | Byte written |
| tx_commit | input | 1 | Mark a transmit buffer as loaded |
| tx_commit_sel | input | 1 | Buffer marked by `tx_commit` |
| tx_start | input | 1 | Request to send the current transmit buffer |
| tx_bit | output | 1 | Serial transmit bit |
| tx_vld | output | 1 | `tx_bit` carries a new bit this cycle |
| tx_done | output | 1 | One-cycle pulse with the last transmitted bit |
| tx_busy | output | 1 | Transmit frame in progress |
| tx_cur | output | 1 | Current transmit buffer |
| tx_full | output | 2 | Committed transmit buffers, bit per buffer |
| tx_overrun | output | 1 | A transmit start was refused |
| rx_bit | input | 1 | Serial receive bit, taken when `bit_en` is high |
| rx_start | input | 1 | Request to capture into the current receive buffer |
| rx_release | input | 1 | Host frees a receive buffer |
| rx_release_sel | input | 1 | Buffer freed by `rx_release` |
| rx_rd_sel | input | 1 | Receive buffer read |
| rx_rd_addr | input | $clog2(BUF_BYTES) | Byte address within the buffer |
| rx_rd_data | output | 8 | Byte read, one cycle after the address |
| rx_busy | output | 1 | Receive frame in progress |
| rx_done | output | 1 | One-cycle pulse after the last received bit |
| rx_cur | output | 1 | Current receive buffer |
| rx_full | output | 2 | Receive buffers holding an unreleased frame |
| fcs_error | output | 1 | Last received frame failed its FCS check |
| rx_overrun | output | 1 | A receive start was refused |

## Verification
The hardest state to reach is a receive start that meets a buffer still holding a frame. It needs two complete frames captured back to back with no release in between, so that the pointer wraps onto an occupied buffer. The bench builds full frames from byte patterns, computes their FCS arithmetically, and drives them bit by bit, some with a sparse strobe. One frame has a flipped data bit and another a flipped FCS bit, so the error flag is set while the buffers fill. The refused start, the release and the re-accepted start then follow on that state.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam int unsigned FCS_W     = 32;
  localparam int unsigned FCS_BYTES = FCS_W / 8;
  localparam logic [FCS_W-1:0] FCS_POLY = 32'h04C1_1DB7;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_LOAD,
    TX_DATA,
    TX_FCS
  } tx_state_t;

  typedef enum logic {
    RX_IDLE,
    RX_RUN
  } rx_state_t;

  // One serial CRC step, MSB-first shift, data bit into the feedback.
  function automatic logic [FCS_W-1:0] crc_step(input logic [FCS_W-1:0] c, input logic d);
    logic fb;
    fb = c[FCS_W-1] ^ d;
    return {c[FCS_W-2:0], 1'b0} ^ (fb ? FCS_POLY : '0);
  endfunction

endpackage

// File: rtl/fcs_dpram.sv
module fcs_dpram #(
  parameter int DW    = 8,
  parameter int DEPTH = 160,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fcs_tx_engine.sv
module fcs_tx_engine
  import fcs_pkg::*;
#(
  parameter int BUF_BYTES = 80,
  parameter int AW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          base_sel,
  input  logic          bit_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          tx_bit,
  output logic          tx_vld,
  output logic          done,
  output logic          finish,
  output logic          busy
);

  localparam int PAY_BYTES = BUF_BYTES - FCS_BYTES;
  localparam int BIW       = $clog2(BUF_BYTES);
  localparam int CNTW      = $clog2(FCS_W);

  tx_state_t        state;
  logic             wait_q;
  logic [7:0]       byte_sr;
  logic [2:0]       bit_idx;
  logic [BIW-1:0]   byte_idx;
  logic [FCS_W-1:0] crc;
  logic [FCS_W-1:0] crc_nxt;
  logic [FCS_W-1:0] fcs_sr;
  logic [CNTW-1:0]  fcs_cnt;

  assign crc_nxt = crc_step(crc, byte_sr[0]);
  assign busy    = (state != TX_IDLE);
  assign finish  = (state == TX_FCS) && bit_en && (fcs_cnt == CNTW'(FCS_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_IDLE;
      wait_q   <= 1'b0;
      byte_sr  <= '0;
      bit_idx  <= '0;
      byte_idx <= '0;
      crc      <= '1;
      fcs_sr   <= '0;
      fcs_cnt  <= '0;
      rd_addr  <= '0;
      tx_bit   <= 1'b0;
      tx_vld   <= 1'b0;
      done     <= 1'b0;
    end else begin
      tx_vld <= 1'b0;
      done   <= 1'b0;
      unique case (state)
        TX_IDLE: begin
          if (start) begin
            rd_addr  <= base_sel ? AW'(BUF_BYTES) : '0;
            byte_idx <= '0;
            bit_idx  <= '0;
            crc      <= '1;
            wait_q   <= 1'b0;
            state    <= TX_LOAD;
          end
        end
        TX_LOAD: begin
          // the synchronous read needs two edges before the first byte is valid
          wait_q <= 1'b1;
          if (wait_q) begin
            byte_sr <= rd_data;
            rd_addr <= rd_addr + 1'b1;
            state   <= TX_DATA;
          end
        end
        TX_DATA: begin
          if (bit_en) begin
            tx_bit  <= byte_sr[0];
            tx_vld  <= 1'b1;
            crc     <= crc_nxt;
            byte_sr <= byte_sr >> 1;
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) begin
              byte_sr  <= rd_data;
              rd_addr  <= rd_addr + 1'b1;
              byte_idx <= byte_idx + 1'b1;
              if (byte_idx == BIW'(PAY_BYTES - 1)) begin
                fcs_sr  <= ~crc_nxt;
                fcs_cnt <= '0;
                state   <= TX_FCS;
              end
            end
          end
        end
        TX_FCS: begin
          if (bit_en) begin
            tx_bit  <= fcs_sr[FCS_W-1];
            tx_vld  <= 1'b1;
            fcs_sr  <= fcs_sr << 1;
            fcs_cnt <= fcs_cnt + 1'b1;
            if (finish) begin
              done  <= 1'b1;
              state <= TX_IDLE;
            end
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  // R4
  tx_vld_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    tx_vld |-> $past(bit_en));

  // R5
  tx_done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  tx_done_with_bit_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> tx_vld);

endmodule

// File: rtl/fcs_rx_engine.sv
module fcs_rx_engine
  import fcs_pkg::*;
#(
  parameter int BUF_BYTES = 80,
  parameter int AW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          base_sel,
  input  logic          bit_en,
  input  logic          rx_bit,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic          done,
  output logic          finish,
  output logic          fcs_error,
  output logic          busy
);

  localparam int FRAME_BITS = BUF_BYTES * 8;
  localparam int DATA_BITS  = FRAME_BITS - FCS_W;
  localparam int CW         = $clog2(FRAME_BITS);

  rx_state_t        state;
  logic [CW-1:0]    bit_cnt;
  logic [7:0]       byte_sr;
  logic [7:0]       byte_nxt;
  logic [FCS_W-1:0] crc;
  logic [FCS_W-1:0] fcs_rx;
  logic [FCS_W-1:0] fcs_nxt;
  logic [AW-1:0]    base;

  assign byte_nxt = {rx_bit, byte_sr[7:1]};
  assign fcs_nxt  = {fcs_rx[FCS_W-2:0], rx_bit};
  assign busy     = (state == RX_RUN);
  assign finish   = (state == RX_RUN) && bit_en && (bit_cnt == CW'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      bit_cnt   <= '0;
      byte_sr   <= '0;
      crc       <= '1;
      fcs_rx    <= '0;
      base      <= '0;
      we        <= 1'b0;
      waddr     <= '0;
      wdata     <= '0;
      done      <= 1'b0;
      fcs_error <= 1'b0;
    end else begin
      we   <= 1'b0;
      done <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (start) begin
            base      <= base_sel ? AW'(BUF_BYTES) : '0;
            bit_cnt   <= '0;
            crc       <= '1;
            fcs_error <= 1'b0;
            state     <= RX_RUN;
          end
        end
        RX_RUN: begin
          if (bit_en) begin
            byte_sr <= byte_nxt;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt[2:0] == 3'd7) begin
              we    <= 1'b1;
              wdata <= byte_nxt;
              waddr <= base + AW'(bit_cnt >> 3);
            end
            if (bit_cnt < CW'(DATA_BITS)) crc <= crc_step(crc, rx_bit);
            else                          fcs_rx <= fcs_nxt;
            if (finish) begin
              done      <= 1'b1;
              fcs_error <= (fcs_nxt != ~crc);
              state     <= RX_IDLE;
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R7
  rx_write_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> $past(bit_en));

  // R8
  rx_done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  rx_error_held_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(fcs_error));

endmodule

// File: rtl/pingpong_fcs_engine.sv
module pingpong_fcs_engine
  import fcs_pkg::*;
#(
  parameter int BUF_BYTES = 80
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bit_en,
  input  logic                         tx_wr_en,
  input  logic                         tx_wr_sel,
  input  logic [$clog2(BUF_BYTES)-1:0] tx_wr_addr,
  input  logic [7:0]                   tx_wr_data,
  input  logic                         tx_commit,
  input  logic                         tx_commit_sel,
  input  logic                         tx_start,
  output logic                         tx_bit,
  output logic                         tx_vld,
  output logic                         tx_done,
  output logic                         tx_busy,
  output logic                         tx_cur,
  output logic [1:0]                   tx_full,
  output logic                         tx_overrun,
  input  logic                         rx_bit,
  input  logic                         rx_start,
  input  logic                         rx_release,
  input  logic                         rx_release_sel,
  input  logic                         rx_rd_sel,
  input  logic [$clog2(BUF_BYTES)-1:0] rx_rd_addr,
  output logic [7:0]                   rx_rd_data,
  output logic                         rx_busy,
  output logic                         rx_done,
  output logic                         rx_cur,
  output logic [1:0]                   rx_full,
  output logic                         fcs_error,
  output logic                         rx_overrun
);

  localparam int DEPTH = 2 * BUF_BYTES;
  localparam int AW    = $clog2(DEPTH);

  logic          tx_accept, tx_refuse, tx_fin;
  logic          rx_accept, rx_refuse, rx_fin;
  logic          tx_we;
  logic [AW-1:0] tx_waddr, tx_raddr;
  logic [7:0]    tx_rdata;
  logic          rx_we;
  logic [AW-1:0] rx_waddr, rx_raddr;
  logic [7:0]    rx_wdata;

  assign tx_accept = tx_start && !tx_busy &&  tx_full[tx_cur];
  assign tx_refuse = tx_start && !tx_busy && !tx_full[tx_cur];
  assign rx_accept = rx_start && !rx_busy && !rx_full[rx_cur];
  assign rx_refuse = rx_start && !rx_busy &&  rx_full[rx_cur];

  assign tx_we    = tx_wr_en && (int'(tx_wr_addr) < BUF_BYTES);
  assign tx_waddr = AW'(tx_wr_addr) + (tx_wr_sel ? AW'(BUF_BYTES) : '0);
  assign rx_raddr = AW'(rx_rd_addr) + (rx_rd_sel ? AW'(BUF_BYTES) : '0);

  fcs_dpram #(.DW(8), .DEPTH(DEPTH), .AW(AW)) u_tx_mem (
    .clk   (clk),
    .we    (tx_we),
    .waddr (tx_waddr),
    .wdata (tx_wr_data),
    .raddr (tx_raddr),
    .rdata (tx_rdata)
  );

  fcs_dpram #(.DW(8), .DEPTH(DEPTH), .AW(AW)) u_rx_mem (
    .clk   (clk),
    .we    (rx_we),
    .waddr (rx_waddr),
    .wdata (rx_wdata),
    .raddr (rx_raddr),
    .rdata (rx_rd_data)
  );

  fcs_tx_engine #(.BUF_BYTES(BUF_BYTES), .AW(AW)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .start    (tx_accept),
    .base_sel (tx_cur),
    .bit_en   (bit_en),
    .rd_addr  (tx_raddr),
    .rd_data  (tx_rdata),
    .tx_bit   (tx_bit),
    .tx_vld   (tx_vld),
    .done     (tx_done),
    .finish   (tx_fin),
    .busy     (tx_busy)
  );

  fcs_rx_engine #(.BUF_BYTES(BUF_BYTES), .AW(AW)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .start     (rx_accept),
    .base_sel  (rx_cur),
    .bit_en    (bit_en),
    .rx_bit    (rx_bit),
    .we        (rx_we),
    .waddr     (rx_waddr),
    .wdata     (rx_wdata),
    .done      (rx_done),
    .finish    (rx_fin),
    .fcs_error (fcs_error),
    .busy      (rx_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_full    <= '0;
      tx_cur     <= 1'b0;
      tx_overrun <= 1'b0;
      rx_full    <= '0;
      rx_cur     <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (tx_accept)      tx_overrun <= 1'b0;
      else if (tx_refuse) tx_overrun <= 1'b1;
      if (tx_fin) begin
        tx_full[tx_cur] <= 1'b0;
        tx_cur          <= ~tx_cur;
      end
      if (tx_commit) tx_full[tx_commit_sel] <= 1'b1;

      if (rx_accept)      rx_overrun <= 1'b0;
      else if (rx_refuse) rx_overrun <= 1'b1;
      if (rx_release) rx_full[rx_release_sel] <= 1'b0;
      if (rx_fin) begin
        rx_full[rx_cur] <= 1'b1;
        rx_cur          <= ~rx_cur;
      end
    end
  end

  // R6
  tx_refused_start_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_start && !tx_busy && !tx_full[tx_cur]) |=> (tx_overrun && !tx_busy));

  // R10
  rx_refused_start_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_start && !rx_busy && rx_full[rx_cur]) |=> (rx_overrun && !rx_busy));

  // R5
  tx_pointer_flip_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (tx_cur != $past(tx_cur)));

  // R9
  rx_pointer_flip_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> (rx_cur != $past(rx_cur)));

  // R11
  tx_busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && tx_start) |=> $stable(tx_overrun));

  // R11
  rx_busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_busy && rx_start) |=> $stable(rx_overrun));

endmodule

// File: tb/pingpong_fcs_engine_bench.sv
`timescale 1ns/1ps
module pingpong_fcs_engine_bench;

  localparam int NB = 80;
  localparam int PB = 76;
  localparam int FB = NB * 8;
  localparam int DB = PB * 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       tx_wr_en = 1'b0, tx_wr_sel = 1'b0;
  logic [6:0] tx_wr_addr = '0;
  logic [7:0] tx_wr_data = '0;
  logic       tx_commit = 1'b0, tx_commit_sel = 1'b0, tx_start = 1'b0;
  logic       tx_bit, tx_vld, tx_done, tx_busy, tx_cur, tx_overrun;
  logic [1:0] tx_full;
  logic       rx_bit = 1'b0, rx_start = 1'b0, rx_release = 1'b0, rx_release_sel = 1'b0;
  logic       rx_rd_sel = 1'b0;
  logic [6:0] rx_rd_addr = '0;
  logic [7:0] rx_rd_data;
  logic       rx_busy, rx_done, rx_cur, fcs_error, rx_overrun;
  logic [1:0] rx_full;

  pingpong_fcs_engine #(.BUF_BYTES(NB)) u_pingpong_fcs_engine (
    .clk, .rst, .bit_en,
    .tx_wr_en, .tx_wr_sel, .tx_wr_addr, .tx_wr_data,
    .tx_commit, .tx_commit_sel, .tx_start,
    .tx_bit, .tx_vld, .tx_done, .tx_busy, .tx_cur, .tx_full, .tx_overrun,
    .rx_bit, .rx_start, .rx_release, .rx_release_sel,
    .rx_rd_sel, .rx_rd_addr, .rx_rd_data,
    .rx_busy, .rx_done, .rx_cur, .rx_full, .fcs_error, .rx_overrun
  );

  int   tests = 0;
  int   fails = 0;
  logic frm [FB];

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int p, input int i);
    if (i >= PB) return 8'hA5 ^ 8'(p);
    case (p)
      0:       return 8'h00;
      1:       return 8'hFF;
      2:       return 8'(i);
      default: return 8'((i * 73 + p * 11) ^ (i / 4));
    endcase
  endfunction

  function automatic logic [31:0] ref_crc();
    logic [31:0] c;
    logic fb;
    c = '1;
    for (int k = 0; k < DB; k++) begin
      fb = c[31] ^ frm[k];
      c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
    end
    return c;
  endfunction

  task automatic build(input int p);
    logic [7:0]  b;
    logic [31:0] c;
    for (int k = 0; k < DB; k++) begin
      b = pat(p, k / 8);
      frm[k] = b[k % 8];
    end
    c = ref_crc();
    for (int j = 0; j < 32; j++) frm[DB + j] = ~c[31 - j];
  endtask

  task automatic tx_send(input int sel, input int p, input int gap, input bit mid);
    int n, cyc, viol, md, mf, extra;
    logic prev_en, done_ok;
    build(p);
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      tx_wr_en = 1'b1; tx_wr_sel = sel[0]; tx_wr_addr = 7'(i); tx_wr_data = pat(p, i);
    end
    @(negedge clk);
    tx_wr_en = 1'b0; tx_commit = 1'b1; tx_commit_sel = sel[0];
    @(negedge clk);
    tx_commit = 1'b0;
    chk("R5 commit sets full bit", tx_full[sel], 1);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    chk("R6 accepted start clears overrun", tx_overrun, 0);
    n = 0; cyc = 0; viol = 0; md = 0; mf = 0; extra = 0; done_ok = 1'b0;
    while (n < FB && cyc < 20000) begin
      bit_en   = ((cyc % gap) == 0);
      tx_start = mid && (cyc == 300);
      prev_en  = bit_en;
      @(negedge clk);
      if (tx_vld) begin
        if (!prev_en) viol++;
        if (tx_bit !== frm[n]) begin
          if (n < DB) md++; else mf++;
        end
        if (n == FB - 1) done_ok = tx_done;
        else if (tx_done) extra++;
        n++;
      end
      cyc++;
    end
    tx_start = 1'b0;
    chk("R4 bit count per frame", n, FB);
    chk("R4 vld without prior strobe", viol, 0);
    chk("R2 data bit mismatches", md, 0);
    chk("R3 fcs bit mismatches", mf, 0);
    chk("R5 done with last bit", done_ok, 1);
    chk("R5 early done pulses", extra, 0);
    chk("R5 sent buffer released", tx_full[sel], 0);
    chk("R5 pointer toggled", tx_cur, !sel[0]);
    if (mid) chk("R11 busy start leaves overrun", tx_overrun, 0);
    viol = 0;
    bit_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (tx_vld || tx_busy) viol++;
    end
    bit_en = 1'b0;
    chk("R4 no bits after frame end", viol, 0);
  endtask

  task automatic rx_recv(input int p, input int flip, input int gap, input bit mid,
                         input bit exp_err, input int sel);
    build(p);
    if (flip >= 0) frm[flip] = ~frm[flip];
    @(negedge clk);
    rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
    chk("R7 receive start accepted", rx_busy, 1);
    chk("R8 accepted start clears error", fcs_error, 0);
    chk("R10 accepted start clears overrun", rx_overrun, 0);
    for (int k = 0; k < FB; k++) begin
      for (int g = 1; g < gap; g++) begin
        bit_en = 1'b0; rx_bit = k[0];
        @(negedge clk);
      end
      bit_en = 1'b1; rx_bit = frm[k]; rx_start = mid && (k == 300);
      @(negedge clk);
    end
    bit_en = 1'b0; rx_start = 1'b0;
    chk("R8 done after last bit", rx_done, 1);
    chk("R8 fcs verdict", fcs_error, exp_err);
    chk("R9 filled buffer marked", rx_full[sel], 1);
    chk("R9 pointer toggled", rx_cur, !sel[0]);
    @(negedge clk);
    chk("R8 done is one cycle", rx_done, 0);
    repeat (4) @(negedge clk);
    chk("R8 verdict held", fcs_error, exp_err);
    if (mid) chk("R11 busy start leaves overrun", rx_overrun, 0);
  endtask

  task automatic read_rx(input int sel);
    int mism;
    logic [7:0] e;
    mism = 0;
    for (int a = 0; a < NB; a++) begin
      @(negedge clk);
      rx_rd_sel = sel[0]; rx_rd_addr = 7'(a);
      @(negedge clk);
      for (int b = 0; b < 8; b++) e[b] = frm[a * 8 + b];
      if (rx_rd_data !== e) mism++;
    end
    chk("R7 stored bytes mismatched", mism, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 full masks", {tx_full, rx_full}, 0);
    chk("R1 busy and pulses", {tx_busy, rx_busy, tx_vld, tx_done, rx_done, tx_bit}, 0);
    chk("R1 flags", {tx_overrun, rx_overrun, fcs_error}, 0);
    chk("R1 pointers", {tx_cur, rx_cur}, 0);

    // R6: nothing committed yet
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    chk("R6 empty start sets overrun", tx_overrun, 1);
    chk("R6 empty start stays idle", tx_busy, 0);

    tx_send(0, 0, 1, 1'b0);
    tx_send(1, 1, 1, 1'b1);
    tx_send(0, 2, 3, 1'b0);
    tx_send(1, 3, 1, 1'b0);

    rx_recv(2, -1, 1, 1'b0, 1'b0, 0);
    read_rx(0);
    rx_recv(3, 100, 2, 1'b0, 1'b1, 1);

    // R10: both buffers full, pointer back on A
    @(negedge clk);
    rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
    chk("R10 full start sets overrun", rx_overrun, 1);
    chk("R10 full start stays idle", rx_busy, 0);
    chk("R10 refused start keeps verdict", fcs_error, 1);
    chk("R9 both buffers full", rx_full, 2'b11);

    rx_release = 1'b1; rx_release_sel = 1'b0;
    @(negedge clk);
    rx_release = 1'b0;
    chk("R9 release clears bit", rx_full, 2'b10);

    rx_recv(4, 620, 1, 1'b0, 1'b1, 0);
    read_rx(0);

    rx_release = 1'b1; rx_release_sel = 1'b1;
    @(negedge clk);
    rx_release_sel = 1'b0;
    @(negedge clk);
    rx_release = 1'b0;
    chk("R9 all released", rx_full, 2'b00);
    rx_recv(5, -1, 1, 1'b1, 1'b0, 1);
    read_rx(1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule